// File: doc/BRIEF.md
# Multi-Channel Event Timer

A memory-mapped event timer. It has one free-running main counter and a small set of comparator channels. Each channel compares its match value against the counter. On a match it records an interrupt status bit and drives one of a bank of interrupt lines. The line is either held for as long as the status bit is set, or pulsed once. Software configures the block over a simple 32-bit register bus. It reads the block's identity and tick period, starts and stops the counter, loads the counter while it is stopped, and arms each channel for one-shot or periodic operation.

Periodic channels reload themselves. Each match adds a stored period to the comparator. The period is loaded through a two-write sequence: after a configuration write that sets both the periodic bit and the value-set bit, the first comparator write lands in the match value and the second lands in the period. A global legacy-routing bit pins channel 0 to interrupt line 0 and channel 1 to interrupt line 8, whatever their route fields hold. Read data is combinational on the address; writes take effect at the clock edge where `bus_sel` and `bus_we` are both high.

Top module: `evtmr_top`

## Requirements
- R1: The identity register (offset 0x000) reads vendor ID in bits 31:16, channel count minus one in bits 12:8 and revision in bits 7:0. The tick-period register (offset 0x004) reads the femtosecond period parameter. Writes to either leave them unchanged.
- R2: While the run bit (bit 0 of the global register at 0x010) is set, the counter (offset 0x0F0) advances by exactly one per clock. While the run bit is clear, the counter holds its value.
- R3: A counter write takes effect only while the run bit is clear. While the counter runs, a counter write is ignored.
- R4: A match occurs when a running counter equals a channel's comparator. It sets that channel's bit n of the status register (offset 0x020) only if the channel's interrupt-enable bit (configuration bit 2) is set.
- R5: In one-shot mode a channel fires once, and its comparator (channel base + 0x08) keeps the written value.
- R6: In periodic mode (configuration bit 3) every match fires and adds the stored period to the comparator, so matches repeat at that period.
- R7: A configuration write with bits 3 and 6 both set arms a load sequence. The next comparator write sets the match value and the one after it sets the period. Bit 6 reads 1 until the period write, then reads 0.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: With configuration bit 1 set (level), the routed interrupt line stays high while the channel's status bit is set. With bit 1 clear (edge), the line pulses for one clock per match.
- R10: The route field (configuration bits 13:9) selects the interrupt line. With the global legacy bit (bit 1 at 0x010) set, channel 0 drives line 0 and channel 1 drives line 8, and their route fields are ignored.
- R11: Offsets that hold no register read as zero, and writes to them change nothing. This includes channel slots beyond the channel count and unused offsets inside a channel slot.
- R12: Configuration bit 4 reads the channel's periodic capability and cannot be written. On a channel without that capability, bits 3 and 6 cannot be set and the channel runs one-shot. The other configuration bits (1, 2, 8 and 13:9) read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter ticks on it |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 12 | Byte offset of the register; channel n lives at 0x100 + 0x20*n |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | NUM_IRQ | Interrupt lines |

## Verification
The assertions assume that bus writes arrive as single-cycle strobes at a decoded offset, and that the clock period equals the advertised tick period. They check a counter that either steps by one or stays frozen, status bits that cannot rise without an interrupt enable and fall after a clear, and one-shot comparators that do not move. The stimulus configures every channel while the counter is stopped. It enables interrupts only on the channel under test and keeps periods of at least two ticks, so that each expected pulse train is unambiguous. Random counter start values let the match value cross the counter's wrap point.

// File: rtl/etm_pkg.sv
// Shared constants for the event timer: register offsets, channel
// configuration bit positions and the value-set sequence states.
// Assumes a 12-bit byte address and at most eight channels.
package etm_pkg;

    localparam int ETM_AW      = 12;
    localparam int CH_IDX_W    = 3;
    localparam int CH_SUB_W    = 5;
    localparam int ROUTE_W     = 5;

    typedef logic [ETM_AW-1:0] etm_addr_t;

    localparam etm_addr_t OFS_IDENT  = 12'h000;
    localparam etm_addr_t OFS_TICK   = 12'h004;
    localparam etm_addr_t OFS_GLOBAL = 12'h010;
    localparam etm_addr_t OFS_STATUS = 12'h020;
    localparam etm_addr_t OFS_COUNT  = 12'h0F0;

    localparam logic [3:0]          CH_REGION = 4'h1;
    localparam logic [CH_SUB_W-1:0] SUB_CFG   = 5'h00;
    localparam logic [CH_SUB_W-1:0] SUB_CMP   = 5'h08;

    localparam int GLB_RUN    = 0;
    localparam int GLB_LEGACY = 1;

    localparam int CFG_LEVEL     = 1;
    localparam int CFG_INTEN     = 2;
    localparam int CFG_PERIODIC  = 3;
    localparam int CFG_PERCAP    = 4;
    localparam int CFG_VALSET    = 6;
    localparam int CFG_FORCE32   = 8;
    localparam int CFG_ROUTE_LSB = 9;

    typedef enum logic [1:0] {
        VS_IDLE   = 2'd0,
        VS_MATCH  = 2'd1,
        VS_PERIOD = 2'd2
    } vs_phase_e;

endpackage

// File: rtl/etm_main_counter.sv
// Main counter of the event timer. Steps by one per clock while run_i
// is high; a load is accepted only while it is stopped.
// Assumes run_i and ld_i are registered or decoded in the same clock domain.
module etm_main_counter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          ld_i,
    input  logic [DW-1:0] ld_val_i,
    output logic [DW-1:0] cnt_o
);

    logic [DW-1:0] cnt_q;

    // Advance while running, otherwise accept software loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (ld_i) begin
            cnt_q <= ld_val_i;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/etm_channel.sv
// One comparator channel: configuration register, match value, period
// accumulator and the two-write value-set sequence.
// Assumes cfg_we_i and cmp_we_i are never high together.
module etm_channel
    import etm_pkg::*;
#(
    parameter int DW      = 32,
    parameter bit PER_CAP = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DW-1:0]      cnt_i,
    input  logic               run_i,
    input  logic               cfg_we_i,
    input  logic               cmp_we_i,
    input  logic [DW-1:0]      wdata_i,
    output logic [DW-1:0]      cfg_rd_o,
    output logic [DW-1:0]      cmp_o,
    output logic               match_o,
    output logic               int_en_o,
    output logic               level_o,
    output logic               periodic_o,
    output logic [ROUTE_W-1:0] route_o
);

    logic               int_en_q;
    logic               level_q;
    logic               periodic_q;
    logic               force32_q;
    logic [ROUTE_W-1:0] route_q;
    logic [DW-1:0]      cmp_q;
    logic [DW-1:0]      period_q;
    vs_phase_e          phase_q;
    logic               arm_w;

    assign arm_w   = cfg_we_i && PER_CAP && wdata_i[CFG_PERIODIC] && wdata_i[CFG_VALSET];
    assign match_o = run_i && (cnt_i == cmp_q);

    // Latch the writable configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_en_q   <= 1'b0;
            level_q    <= 1'b0;
            periodic_q <= 1'b0;
            force32_q  <= 1'b0;
            route_q    <= '0;
        end else if (cfg_we_i) begin
            int_en_q   <= wdata_i[CFG_INTEN];
            level_q    <= wdata_i[CFG_LEVEL];
            periodic_q <= wdata_i[CFG_PERIODIC] & PER_CAP;
            force32_q  <= wdata_i[CFG_FORCE32];
            route_q    <= wdata_i[CFG_ROUTE_LSB +: ROUTE_W];
        end
    end

    // Comparator, period and value-set sequencing; a bus write beats a reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q    <= '0;
            period_q <= '0;
            phase_q  <= VS_IDLE;
        end else begin
            if (cmp_we_i) begin
                case (phase_q)
                    VS_MATCH: begin
                        cmp_q   <= wdata_i;
                        phase_q <= VS_PERIOD;
                    end
                    VS_PERIOD: begin
                        period_q <= wdata_i;
                        phase_q  <= VS_IDLE;
                    end
                    default: cmp_q <= wdata_i;
                endcase
            end else if (match_o && periodic_q) begin
                cmp_q <= cmp_q + period_q;
            end
            if (arm_w) begin
                phase_q <= VS_MATCH;
            end
        end
    end

    // Assemble the configuration read value.
    always_comb begin
        cfg_rd_o                              = '0;
        cfg_rd_o[CFG_LEVEL]                   = level_q;
        cfg_rd_o[CFG_INTEN]                   = int_en_q;
        cfg_rd_o[CFG_PERIODIC]                = periodic_q;
        cfg_rd_o[CFG_PERCAP]                  = PER_CAP;
        cfg_rd_o[CFG_VALSET]                  = (phase_q != VS_IDLE);
        cfg_rd_o[CFG_FORCE32]                 = force32_q;
        cfg_rd_o[CFG_ROUTE_LSB +: ROUTE_W]    = route_q;
    end

    assign cmp_o      = cmp_q;
    assign int_en_o   = int_en_q;
    assign level_o    = level_q;
    assign periodic_o = periodic_q;
    assign route_o    = route_q;

endmodule

// File: rtl/etm_int_status.sv
// Interrupt status bits with write-one-to-clear, plus a one-clock event
// pulse per hit. A hit in the same clock as a clear wins.
// Assumes hit_i is already gated by each channel's interrupt enable.
module etm_int_status #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit_i,
    input  logic [NCH-1:0] clr_i,
    output logic [NCH-1:0] status_o,
    output logic [NCH-1:0] pulse_o
);

    logic [NCH-1:0] status_q;
    logic [NCH-1:0] pulse_q;

    // Set on hit, clear on a written one, record this clock's hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            pulse_q  <= '0;
        end else begin
            status_q <= (status_q & ~clr_i) | hit_i;
            pulse_q  <= hit_i;
        end
    end

    assign status_o = status_q;
    assign pulse_o  = pulse_q;

endmodule

// File: rtl/etm_irq_router.sv
// Steers each channel's level or pulse source onto an interrupt line.
// Legacy mode pins channel 0 and channel 1 to fixed lines.
// Assumes NCH >= 2 and that both fixed lines exist in the bank.
module etm_irq_router
    import etm_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int NLINES = 24,
    parameter int LEG_A  = 0,
    parameter int LEG_B  = 8
) (
    input  logic [NCH-1:0]              status_i,
    input  logic [NCH-1:0]              pulse_i,
    input  logic [NCH-1:0]              level_i,
    input  logic [NCH-1:0][ROUTE_W-1:0] route_i,
    input  logic                        legacy_i,
    output logic [NLINES-1:0]           irq_o
);

    logic [NCH-1:0][ROUTE_W-1:0] target_w;
    logic [NCH-1:0]              src_w;

    for (genvar c = 0; c < NCH; c++) begin : g_target
        // Choose the level or pulse source of this channel.
        assign src_w[c] = level_i[c] ? status_i[c] : pulse_i[c];
        if (c == 0) begin : g_leg_a
            assign target_w[c] = legacy_i ? ROUTE_W'(LEG_A) : route_i[c];
        end else if (c == 1) begin : g_leg_b
            assign target_w[c] = legacy_i ? ROUTE_W'(LEG_B) : route_i[c];
        end else begin : g_plain
            assign target_w[c] = route_i[c];
        end
    end

    // OR every channel onto the line it targets.
    always_comb begin
        irq_o = '0;
        for (int c = 0; c < NCH; c++) begin
            for (int ln = 0; ln < NLINES; ln++) begin
                if (target_w[c] == ROUTE_W'(ln)) begin
                    irq_o[ln] = irq_o[ln] | src_w[c];
                end
            end
        end
    end

endmodule

// File: rtl/evtmr_top.sv
// Event timer top: register decode, global run and legacy bits, one main
// counter, NUM_CH comparator channels, status and interrupt routing.
// Assumes DW is 32, NUM_CH <= 8 and NUM_IRQ > 8.
module evtmr_top
    import etm_pkg::*;
#(
    parameter int          NUM_CH       = 3,
    parameter int          DW           = 32,
    parameter int          NUM_IRQ      = 24,
    parameter logic [15:0] VENDOR_ID    = 16'h1A2B,
    parameter logic [7:0]  REV_ID       = 8'h01,
    parameter logic [31:0] TICK_FS      = 32'd4000000,
    parameter logic [31:0] PER_CAP_MASK = 32'h0000_0003
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ETM_AW-1:0]  bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic [NUM_IRQ-1:0] irq_o
);

    localparam logic [DW-1:0] IDENT_VAL = {VENDOR_ID, 3'b000, 5'(NUM_CH - 1), REV_ID};

    logic                           wr_w;
    logic                           in_ch_w;
    logic [CH_IDX_W-1:0]            ch_idx_w;
    logic [CH_SUB_W-1:0]            ch_sub_w;
    logic                           run_q;
    logic                           legacy_q;
    logic [DW-1:0]                  cnt;
    logic [NUM_CH-1:0]              status;
    logic [NUM_CH-1:0]              pulse;
    logic [NUM_CH-1:0]              hit;
    logic [NUM_CH-1:0]              clr;
    logic [NUM_CH-1:0]              ch_cfg_we;
    logic [NUM_CH-1:0]              ch_cmp_we;
    logic [NUM_CH-1:0]              ch_match;
    logic [NUM_CH-1:0]              ch_int_en;
    logic [NUM_CH-1:0]              ch_level;
    logic [NUM_CH-1:0]              ch_periodic;
    logic [NUM_CH-1:0][ROUTE_W-1:0] ch_route;
    logic [NUM_CH-1:0][DW-1:0]      ch_cfg_rd;
    logic [NUM_CH-1:0][DW-1:0]      ch_cmp;

    assign wr_w     = bus_sel && bus_we;
    assign in_ch_w  = (bus_addr[ETM_AW-1:8] == CH_REGION);
    assign ch_idx_w = bus_addr[7:5];
    assign ch_sub_w = bus_addr[4:0];

    // Global run and legacy-route bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            legacy_q <= 1'b0;
        end else if (wr_w && bus_addr == OFS_GLOBAL) begin
            run_q    <= bus_wdata[GLB_RUN];
            legacy_q <= bus_wdata[GLB_LEGACY];
        end
    end

    assign clr = (wr_w && bus_addr == OFS_STATUS) ? bus_wdata[NUM_CH-1:0] : '0;
    assign hit = ch_match & ch_int_en;

    etm_main_counter #(
        .DW (DW)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_q),
        .ld_i     (wr_w && bus_addr == OFS_COUNT),
        .ld_val_i (bus_wdata),
        .cnt_o    (cnt)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_cfg_we[c] = wr_w && in_ch_w && ch_idx_w == CH_IDX_W'(c) && ch_sub_w == SUB_CFG;
        assign ch_cmp_we[c] = wr_w && in_ch_w && ch_idx_w == CH_IDX_W'(c) && ch_sub_w == SUB_CMP;

        etm_channel #(
            .DW      (DW),
            .PER_CAP (PER_CAP_MASK[c])
        ) u_channel (
            .clk        (clk),
            .rst_n      (rst_n),
            .cnt_i      (cnt),
            .run_i      (run_q),
            .cfg_we_i   (ch_cfg_we[c]),
            .cmp_we_i   (ch_cmp_we[c]),
            .wdata_i    (bus_wdata),
            .cfg_rd_o   (ch_cfg_rd[c]),
            .cmp_o      (ch_cmp[c]),
            .match_o    (ch_match[c]),
            .int_en_o   (ch_int_en[c]),
            .level_o    (ch_level[c]),
            .periodic_o (ch_periodic[c]),
            .route_o    (ch_route[c])
        );
    end

    etm_int_status #(
        .NCH (NUM_CH)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit),
        .clr_i    (clr),
        .status_o (status),
        .pulse_o  (pulse)
    );

    etm_irq_router #(
        .NCH    (NUM_CH),
        .NLINES (NUM_IRQ),
        .LEG_A  (0),
        .LEG_B  (8)
    ) u_router (
        .status_i (status),
        .pulse_i  (pulse),
        .level_i  (ch_level),
        .route_i  (ch_route),
        .legacy_i (legacy_q),
        .irq_o    (irq_o)
    );

    // Read multiplexer; anything undecoded returns zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_IDENT:  bus_rdata = IDENT_VAL;
            OFS_TICK:   bus_rdata = TICK_FS;
            OFS_GLOBAL: begin
                bus_rdata[GLB_RUN]    = run_q;
                bus_rdata[GLB_LEGACY] = legacy_q;
            end
            OFS_STATUS: bus_rdata[NUM_CH-1:0] = status;
            OFS_COUNT:  bus_rdata = cnt;
            default: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (in_ch_w && ch_idx_w == CH_IDX_W'(c)) begin
                        if (ch_sub_w == SUB_CFG) begin
                            bus_rdata = ch_cfg_rd[c];
                        end else if (ch_sub_w == SUB_CMP) begin
                            bus_rdata = ch_cmp[c];
                        end
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/etm_checker.sv
// Temporal checks on the event timer, bound to every evtmr_top instance.
// Assumes synchronous active-low reset and registered status and counter.
module etm_checker
    import etm_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DW     = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_sel,
    input logic                      bus_we,
    input logic [ETM_AW-1:0]         bus_addr,
    input logic                      run_q,
    input logic [DW-1:0]             cnt,
    input logic [NUM_CH-1:0]         status,
    input logic [NUM_CH-1:0]         hit,
    input logic [NUM_CH-1:0]         clr,
    input logic [NUM_CH-1:0]         ch_int_en,
    input logic [NUM_CH-1:0]         ch_match,
    input logic [NUM_CH-1:0]         ch_periodic,
    input logic [NUM_CH-1:0]         ch_cmp_we,
    input logic [NUM_CH-1:0][DW-1:0] ch_cmp
);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> cnt == $past(cnt) + 1'b1); // R2

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !(bus_sel && bus_we && bus_addr == OFS_COUNT)) |=> $stable(cnt)); // R3

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_STATUS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            (!status[c] && !ch_int_en[c]) |=> !status[c]); // R4

        AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_match[c] && !ch_periodic[c] && !ch_cmp_we[c]) |=> $stable(ch_cmp[c])); // R5

        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[c] && !hit[c]) |=> !status[c]); // R8
    end

endmodule

bind evtmr_top etm_checker #(
    .NUM_CH (NUM_CH),
    .DW     (DW)
) u_etm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .run_q       (run_q),
    .cnt         (cnt),
    .status      (status),
    .hit         (hit),
    .clr         (clr),
    .ch_int_en   (ch_int_en),
    .ch_match    (ch_match),
    .ch_periodic (ch_periodic),
    .ch_cmp_we   (ch_cmp_we),
    .ch_cmp      (ch_cmp)
);

// File: tb/test_evtmr_top.sv
`timescale 1ns/1ps
module test_evtmr_top;

    localparam int          NCH   = 3;
    localparam int          NIRQ  = 24;
    localparam logic [15:0] VEND  = 16'h1A2B;
    localparam logic [7:0]  REV   = 8'h01;
    localparam logic [31:0] TICK  = 32'd4000000;
    localparam logic [31:0] PCAP  = 32'h0000_0003;

    localparam logic [11:0] A_IDENT  = 12'h000;
    localparam logic [11:0] A_TICK   = 12'h004;
    localparam logic [11:0] A_GLOBAL = 12'h010;
    localparam logic [11:0] A_STATUS = 12'h020;
    localparam logic [11:0] A_COUNT  = 12'h0F0;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_we = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NIRQ-1:0] irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    evtmr_top #(
        .NUM_CH       (NCH),
        .DW           (32),
        .NUM_IRQ      (NIRQ),
        .VENDOR_ID    (VEND),
        .REV_ID       (REV),
        .TICK_FS      (TICK),
        .PER_CAP_MASK (PCAP)
    ) i_evtmr_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    function automatic logic [11:0] cfg_a(int c);
        return 12'h100 + 12'(c * 32);
    endfunction

    function automatic logic [11:0] cmp_a(int c);
        return 12'h108 + 12'(c * 32);
    endfunction

    function automatic int line_of(int c, bit leg, int route);
        if (leg && c == 0) return 0;
        if (leg && c == 1) return 8;
        return route;
    endfunction

    // Match j clocks after the run edge: first at dc+1, then every p if periodic.
    function automatic bit fires(int j, int dc, int p, bit per);
        int k;
        k = j - (dc + 1);
        if (k < 0) return 1'b0;
        if (per) return (k % p) == 0;
        return k == 0;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bw(logic [11:0] a, logic [31:0] d);
        bus_sel   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
        bus_we  = 1'b0;
    endtask

    task automatic br(logic [11:0] a, output logic [31:0] d);
        bus_sel  = 1'b1;
        bus_we   = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Configure a channel while stopped, run it, and compare the irq bank each clock.
    task automatic run_trial(int c, bit per, bit lvl, bit ie, int route, bit leg,
                             logic [31:0] v, int dc, int p, string req);
        logic [31:0] cfgw;
        logic [31:0] rd;
        logic [NIRQ-1:0] expv;
        bit eff_per;
        bit fired;
        bit f;
        int ln;
        int bad;
        int win;
        eff_per = per && PCAP[c];
        bw(A_GLOBAL, {30'b0, leg, 1'b0});
        for (int k = 0; k < NCH; k++) bw(cfg_a(k), 32'h0);
        bw(A_STATUS, 32'hFFFF_FFFF);
        bw(A_COUNT, v);
        cfgw = (32'(ie) << 2) | (32'(lvl) << 1) | (32'(route) << 9);
        if (per) cfgw = cfgw | 32'h48;
        bw(cfg_a(c), cfgw);
        bw(cmp_a(c), v + 32'(dc));
        if (eff_per) bw(cmp_a(c), 32'(p));
        bw(A_GLOBAL, {30'b0, leg, 1'b1});
        ln    = line_of(c, leg, route);
        win   = dc + 1 + 3 * p + 4;
        fired = 1'b0;
        bad   = 0;
        for (int j = 1; j <= win; j++) begin
            @(posedge clk);
            @(negedge clk);
            f = ie && fires(j, dc, p, eff_per);
            if (f) fired = 1'b1;
            expv = '0;
            if (lvl ? fired : f) expv[ln] = 1'b1;
            if (irq_o !== expv) begin
                if (bad == 0)
                    $display("FAIL %s irq bank at clock %0d ch%0d: actual %h expected %h",
                             req, j, c, irq_o, expv);
                bad++;
            end
        end
        n_chk++;
        if (bad != 0) n_bad++;
        bw(A_GLOBAL, {30'b0, leg, 1'b0});
        if (ie && fires(win + 1, dc, p, eff_per)) fired = 1'b1;
        br(A_STATUS, rd);
        check("R4", "status after run", rd, ie && fired ? (32'h1 << c) : 32'h0);
        if (!eff_per) begin
            br(cmp_a(c), rd);
            check("R5", "one-shot comparator kept", rd, v + 32'(dc));
        end
        bw(A_STATUS, 32'h0);
        br(A_STATUS, rd);
        check("R8", "zero write keeps status", rd, ie && fired ? (32'h1 << c) : 32'h0);
        bw(A_STATUS, 32'h1 << c);
        br(A_STATUS, rd);
        check("R8", "one write clears status", rd, 32'h0);
        check("R9", "level line drops after clear", 32'(irq_o), 32'h0);
    endtask

    initial begin : main
        logic [31:0] rd;
        logic [31:0] c1;
        logic [31:0] c2;
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        br(A_IDENT, rd);
        check("R1", "identity", rd, {VEND, 3'b000, 5'(NCH - 1), REV});
        br(A_TICK, rd);
        check("R1", "tick period", rd, TICK);
        br(A_GLOBAL, rd);
        check("R2", "global after reset", rd, 32'h0);
        br(A_STATUS, rd);
        check("R8", "status after reset", rd, 32'h0);
        for (int c = 0; c < NCH; c++) begin
            br(cfg_a(c), rd);
            check("R12", "config after reset", rd, 32'(PCAP[c]) << 4);
        end
        check("R9", "irq after reset", 32'(irq_o), 32'h0);

        // Read-only registers
        bw(A_IDENT, 32'hFFFF_FFFF);
        br(A_IDENT, rd);
        check("R1", "identity after write", rd, {VEND, 3'b000, 5'(NCH - 1), REV});
        bw(A_TICK, 32'h0);
        br(A_TICK, rd);
        check("R1", "tick after write", rd, TICK);

        // Unmapped offsets
        bw(12'h040, 32'hFFFF_FFFF);
        br(12'h040, rd);
        check("R11", "unmapped 0x040", rd, 32'h0);
        bw(12'h160, 32'hFFFF_FFFF);
        br(12'h160, rd);
        check("R11", "absent channel slot", rd, 32'h0);
        br(12'h104, rd);
        check("R11", "unused channel sub-offset", rd, 32'h0);
        br(A_STATUS, rd);
        check("R11", "status untouched by stray writes", rd, 32'h0);

        // Counter hold, load, run, load ignored while running
        br(A_COUNT, c1);
        repeat (5) @(negedge clk);
        br(A_COUNT, rd);
        check("R2", "counter holds when stopped", rd, c1);
        bw(A_COUNT, 32'h100);
        br(A_COUNT, rd);
        check("R3", "counter load while stopped", rd, 32'h100);
        bw(A_GLOBAL, 32'h1);
        br(A_COUNT, c1);
        check("R2", "counter at run edge", c1, 32'h100);
        repeat (10) @(negedge clk);
        br(A_COUNT, c2);
        check("R2", "counter step over 10 clocks", c2 - c1, 32'd10);
        bw(A_COUNT, 32'hF000_0000);
        br(A_COUNT, rd);
        check("R3", "load ignored while running", rd, c2 + 32'd1);
        bw(A_GLOBAL, 32'h0);

        // Value-set sequence on a periodic-capable channel
        bw(cfg_a(0), 32'h48);
        br(cfg_a(0), rd);
        check("R7", "value-set armed", rd, 32'h58);
        bw(cmp_a(0), 32'h1234);
        br(cfg_a(0), rd);
        check("R7", "value-set still armed", rd, 32'h58);
        bw(cmp_a(0), 32'd7);
        br(cfg_a(0), rd);
        check("R7", "value-set self-clears", rd, 32'h18);
        br(cmp_a(0), rd);
        check("R7", "first write is match value", rd, 32'h1234);

        // Field readback and capability on a channel without periodic support
        bw(cfg_a(2), 32'h48);
        br(cfg_a(2), rd);
        check("R12", "no periodic on incapable channel", rd, 32'h0);
        bw(cfg_a(1), 32'h0000_3F06 | 32'h100);
        br(cfg_a(1), rd);
        check("R12", "config field readback", rd, 32'h0000_3F16);

        // Directed trials
        run_trial(0, 1'b0, 1'b0, 1'b1, 3, 1'b0, 32'h0000_0010, 0, 2, "R4 R5 R9");
        run_trial(1, 1'b1, 1'b0, 1'b1, 5, 1'b0, 32'h0000_2000, 4, 6, "R6 R9 R10");
        run_trial(1, 1'b1, 1'b0, 1'b1, 5, 1'b1, 32'hFFFF_FFFE, 5, 3, "R6 R10");
        run_trial(0, 1'b0, 1'b1, 1'b1, 17, 1'b1, 32'h0000_0400, 7, 2, "R9 R10");
        run_trial(2, 1'b1, 1'b0, 1'b1, 12, 1'b0, 32'h0000_0800, 3, 4, "R12 R5");
        run_trial(2, 1'b0, 1'b1, 1'b0, 9, 1'b0, 32'h0000_0050, 2, 2, "R4");
        run_trial(0, 1'b1, 1'b1, 1'b1, 8, 1'b0, 32'h7FFF_FFF0, 20, 2, "R6 R9");

        // Constrained random trials
        for (int t = 0; t < 24; t++) begin
            run_trial($urandom_range(0, NCH - 1), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) != 0),
                      $urandom_range(0, NIRQ - 1), 1'($urandom_range(0, 3) == 0),
                      $urandom, $urandom_range(0, 40), $urandom_range(2, 20),
                      "R4 R6 R9 R10");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule